// File: doc/BRIEF.md
# Completion Event Gate with Split Doorbells

The block decides when a completion queue may post an event entry into a shared event queue. It keeps a small state record for every completion queue it tracks. A completion is reported as a one-cycle pulse together with the queue's index. An entry is produced only when the queue is both armed and holding its event credit.

Two doorbells feed this state. Unprivileged software uses the arm doorbell to re-arm a queue. Privileged software uses the credit doorbell to return a queue's event credit after it has consumed that queue's entry. Arming alone can never produce a second entry. Each queue therefore has at most one entry in the event queue at any time, and the event queue cannot overflow.

The event queue is an internal FIFO whose depth equals the number of completion queues. A round-robin arbiter feeds it through a valid/ready stream. Privileged software reads the head index and pops it.

Top module: `evgate_top`

## Requirements
- R1: After reset the event FIFO is empty (`evq_valid`=0, `evq_count`=0) and `cred_err`=0. Every queue starts with its credit held and unarmed, so a completion on a queue that has not been armed produces no entry.
- R2: A queue that is armed, holds its credit and has a completion pending emits one entry carrying its index. When the arm and the completion arrive in the same cycle, the entry is visible in `evq_count` two clock edges after that cycle.
- R3: Emitting an entry clears the queue's armed and credit state. Until its credit is returned, further completions and arms on that queue produce no entry.
- R4: Arm doorbells alone, however many, never create a second entry for a queue. At most one entry per queue is in the FIFO at any time.
- R5: A credit return on a queue that is armed with a completion pending makes the queue emit an entry two clock edges after the return.
- R6: Completions that arrive while a queue is unarmed or has no credit collapse into one pending flag. The flag produces exactly one entry once both conditions hold.
- R7: When several queues become eligible in the same cycle, one entry is enqueued per cycle. They are chosen round-robin, starting with the index just after the last queue granted.
- R8: A credit return on a queue that already holds its credit leaves the queue's state unchanged and sets `cred_err`. The flag stays at 1 until reset.
- R9: `evq_count` never exceeds the number of queues. A pop of an empty FIFO is ignored.
- R10: `evq_pop` removes the head entry. Entries leave in the order they were enqueued, and `evq_idx` shows the head index while `evq_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpl_valid | input | 1 | Completion pulse |
| cmpl_idx | input | IDX_W | Queue index of the completion |
| arm_valid | input | 1 | Unprivileged arm doorbell |
| arm_idx | input | IDX_W | Queue index to arm |
| cred_valid | input | 1 | Privileged credit-return doorbell |
| cred_idx | input | IDX_W | Queue index whose credit returns |
| evq_pop | input | 1 | Privileged pop of the event FIFO head |
| evq_valid | output | 1 | FIFO not empty |
| evq_idx | output | IDX_W | Queue index at the FIFO head |
| evq_count | output | CNT_W | FIFO occupancy |
| cred_err | output | 1 | Sticky duplicate-credit flag |

## Verification
A queue whose credit bit is wrongly set shows up as an extra entry in `evq_count`, two edges after the arm or completion that exposes it. A credit bit wrongly cleared shows up as a missing entry at the same point. A stuck pending flag produces a duplicate entry as soon as the queue's credit returns. A wrong arbiter pointer shows up as the wrong head index on the pop that follows a three-way contention. A duplicate credit that is not flagged shows up on `cred_err` one edge after the doorbell.

// File: rtl/evgate_pkg.sv
package evgate_pkg;

    // Per-queue gating state
    typedef struct packed {
        logic armed;
        logic credit;
        logic pending;
    } cq_state_t;

    localparam cq_state_t CQ_RESET = '{armed: 1'b0, credit: 1'b1, pending: 1'b0};

    function automatic logic idx_hit(input logic valid, input int unsigned idx, input int unsigned me);
        return valid && (idx == me);
    endfunction

endpackage

// File: rtl/evgate_slot.sv
module evgate_slot
    import evgate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmpl_hit,
    input  logic arm_hit,
    input  logic cred_hit,
    input  logic grant,
    output logic req,
    output logic dup_credit
);
    cq_state_t st_q, st_d;

    assign req        = st_q.armed && st_q.credit && st_q.pending;
    assign dup_credit = cred_hit && st_q.credit;

    always_comb begin
        st_d = st_q;
        if (grant) begin
            st_d.armed   = 1'b0;
            st_d.credit  = 1'b0;
            st_d.pending = 1'b0;
        end
        // A completion arriving in the grant cycle is a new event
        if (cmpl_hit) st_d.pending = 1'b1;
        // Re-arming is harmless: credit is zero after a grant
        if (arm_hit)  st_d.armed = 1'b1;
        // Only a return to a queue without credit takes effect
        if (cred_hit && !st_q.credit) st_d.credit = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CQ_RESET;
        else     st_q <= st_d;
    end

    // The arbiter grants only a requesting queue
    p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        grant |-> req);
    // The credit is gone after an emission (R3)
    p_grant_drops_credit_r3: assert property (@(posedge clk) disable iff (rst)
        grant |=> !st_q.credit);
    // Credit comes back only through the privileged doorbell (R4)
    p_credit_only_priv_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.credit) |-> $past(cred_hit));
    // Armed only rises through the arm doorbell (R5)
    p_arm_only_doorbell_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.armed) |-> $past(arm_hit));

endmodule

// File: rtl/evgate_rr_arb.sv
module evgate_rr_arb #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          ready,
    output logic [N-1:0]  grant,
    output logic          valid,
    output logic [IW-1:0] grant_idx
);
    logic [IW-1:0] last_q;

    always_comb begin
        grant     = '0;
        valid     = 1'b0;
        grant_idx = '0;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = int'(last_q) + k;
            if (cand >= N) cand = cand - N;
            if (!valid && req[cand]) begin
                valid     = 1'b1;
                grant_idx = IW'(cand);
            end
        end
        if (!ready) valid = 1'b0;
        if (valid) grant[grant_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)        last_q <= IW'(N - 1);
        else if (valid) last_q <= grant_idx;
    end

    p_onehot_grant_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    p_work_conserving_r7: assert property (@(posedge clk) disable iff (rst)
        (ready && (req != '0)) |-> valid);

endmodule

// File: rtl/evgate_fifo.sv
module evgate_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_q];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_data;
    end

    // The gating must keep the stream from ever seeing a full FIFO
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        !(push && full));
    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    p_pop_empty_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (count == '0));

endmodule

// File: rtl/evgate_top.sv
module evgate_top
    import evgate_pkg::*;
#(
    parameter int NUM_CQ = 4,
    localparam int IDX_W = (NUM_CQ > 1) ? $clog2(NUM_CQ) : 1,
    localparam int CNT_W = $clog2(NUM_CQ + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmpl_valid,
    input  logic [IDX_W-1:0] cmpl_idx,
    input  logic             arm_valid,
    input  logic [IDX_W-1:0] arm_idx,
    input  logic             cred_valid,
    input  logic [IDX_W-1:0] cred_idx,
    input  logic             evq_pop,
    output logic             evq_valid,
    output logic [IDX_W-1:0] evq_idx,
    output logic [CNT_W-1:0] evq_count,
    output logic             cred_err
);
    logic [NUM_CQ-1:0] req, grant, dup;
    logic              ev_valid, ev_ready, fifo_full, fifo_empty;
    logic [IDX_W-1:0]  ev_idx;

    for (genvar g = 0; g < NUM_CQ; g++) begin : g_slot
        evgate_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .cmpl_hit   (idx_hit(cmpl_valid, int'(cmpl_idx), g)),
            .arm_hit    (idx_hit(arm_valid,  int'(arm_idx),  g)),
            .cred_hit   (idx_hit(cred_valid, int'(cred_idx), g)),
            .grant      (grant[g]),
            .req        (req[g]),
            .dup_credit (dup[g])
        );
    end

    evgate_rr_arb #(.N(NUM_CQ)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .ready     (ev_ready),
        .grant     (grant),
        .valid     (ev_valid),
        .grant_idx (ev_idx)
    );

    assign ev_ready = !fifo_full;

    evgate_fifo #(.DEPTH(NUM_CQ), .W(IDX_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (ev_valid),
        .push_data (ev_idx),
        .pop       (evq_pop),
        .head      (evq_idx),
        .count     (evq_count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    assign evq_valid = !fifo_empty;

    always_ff @(posedge clk) begin
        if (rst)        cred_err <= 1'b0;
        else if (|dup)  cred_err <= 1'b1;
    end

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        cred_err |=> cred_err);
    p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(cred_err) |-> $past(cred_valid));
    p_arm_alone_no_push_r4: assert property (@(posedge clk) disable iff (rst)
        (ev_valid) |-> (req != '0));

endmodule

// File: tb/evgate_top_tb_top.sv
module evgate_top_tb_top;
    localparam int NQ    = 4;
    localparam int IDX_W = $clog2(NQ);
    localparam int CNT_W = $clog2(NQ + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmpl_valid = 0, arm_valid = 0, cred_valid = 0, evq_pop = 0;
    logic [IDX_W-1:0] cmpl_idx = '0, arm_idx = '0, cred_idx = '0;
    logic             evq_valid, cred_err;
    logic [IDX_W-1:0] evq_idx;
    logic [CNT_W-1:0] evq_count;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    int sb[$];

    always #2.5 clk = ~clk;

    evgate_top #(.NUM_CQ(NQ)) dut_i (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One cycle of doorbell/completion stimulus
    task automatic drive(input bit cv, input int ci, input bit av, input int ai,
                         input bit rv, input int ri);
        cmpl_valid = cv; cmpl_idx = IDX_W'(ci);
        arm_valid  = av; arm_idx  = IDX_W'(ai);
        cred_valid = rv; cred_idx = IDX_W'(ri);
        @(negedge clk);
        cmpl_valid = 0; arm_valid = 0; cred_valid = 0;
    endtask

    task automatic expect_entry(input int q);
        sb.push_back(q);
    endtask

    // Monitor side: pop the head and compare with the scoreboard
    task automatic pop_check(input string req);
        int exp;
        exp = (sb.size() > 0) ? sb.pop_front() : -1;
        check(evq_valid == 1'b1, req, int'(evq_valid), 1);
        check(int'(evq_idx) == exp, req, int'(evq_idx), exp);
        evq_pop = 1;
        @(negedge clk);
        evq_pop = 0;
    endtask

    // Occupancy bound watched every cycle (R9)
    always @(negedge clk) begin
        if (!rst && !done)
            if (int'(evq_count) > NQ) check(0, "R9", int'(evq_count), NQ);
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        idle(3);
        rst = 0;
        idle(1);
        // R1: reset state
        check(evq_count == 0, "R1", int'(evq_count), 0);
        check(evq_valid == 0, "R1", int'(evq_valid), 0);
        check(cred_err == 0, "R1", int'(cred_err), 0);

        // R2: arm and completion together on queue 3
        drive(1, 3, 1, 3, 0, 0);
        check(evq_count == 0, "R2", int'(evq_count), 0);
        idle(1);
        expect_entry(3);
        check(evq_count == 1, "R2", int'(evq_count), 1);
        pop_check("R10");
        // R3: without credit, new completion and arm give nothing
        drive(1, 3, 1, 3, 0, 0);
        idle(4);
        check(evq_count == 0, "R3", int'(evq_count), 0);

        // R1/R6: completions on unarmed queue 1 collapse
        drive(1, 1, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 0, 0);
        idle(3);
        check(evq_count == 0, "R1", int'(evq_count), 0);
        drive(0, 0, 1, 1, 0, 0);
        idle(1);
        expect_entry(1);
        check(evq_count == 1, "R6", int'(evq_count), 1);
        idle(3);
        check(evq_count == 1, "R6", int'(evq_count), 1);

        // R4: hammer the arm doorbell on queue 1
        for (int i = 0; i < 20; i++) begin
            drive(1, 1, 1, 1, 0, 0);
            check(evq_count == 1, "R4", int'(evq_count), 1);
        end
        idle(3);
        check(evq_count == 1, "R4", int'(evq_count), 1);
        pop_check("R10");
        check(evq_count == 0, "R10", int'(evq_count), 0);

        // R7: three queues eligible together, last grant was queue 1
        drive(1, 2, 0, 0, 0, 0);
        drive(0, 0, 1, 0, 0, 0);
        idle(3);
        check(evq_count == 0, "R7", int'(evq_count), 0);
        drive(1, 0, 1, 2, 1, 3);
        idle(4);
        expect_entry(2); expect_entry(3); expect_entry(0);
        check(evq_count == 3, "R7", int'(evq_count), 3);
        pop_check("R7");
        pop_check("R7");
        pop_check("R7");
        check(cred_err == 0, "R8", int'(cred_err), 0);

        // R5: credit return on armed, pending queue 1
        drive(0, 0, 0, 0, 1, 1);
        check(evq_count == 0, "R5", int'(evq_count), 0);
        idle(1);
        expect_entry(1);
        check(evq_count == 1, "R5", int'(evq_count), 1);
        pop_check("R5");

        // R8: legal return then a duplicate on queue 2
        drive(0, 0, 0, 0, 1, 2);
        check(cred_err == 0, "R8", int'(cred_err), 0);
        drive(0, 0, 0, 0, 1, 2);
        check(cred_err == 1, "R8", int'(cred_err), 1);
        idle(4);
        check(evq_count == 0, "R8", int'(evq_count), 0);
        check(cred_err == 1, "R8", int'(cred_err), 1);

        // R9: pop of an empty FIFO
        evq_pop = 1;
        @(negedge clk);
        evq_pop = 0;
        idle(1);
        check(evq_count == 0, "R9", int'(evq_count), 0);
        check(evq_valid == 0, "R9", int'(evq_valid), 0);

        // R9: fill to full depth
        drive(0, 0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 1, 1);
        drive(0, 0, 0, 0, 1, 3);
        for (int q = 0; q < NQ; q++) begin
            drive(1, q, 1, q, 0, 0);
            expect_entry(q);
        end
        idle(3);
        check(int'(evq_count) == NQ, "R9", int'(evq_count), NQ);
        for (int q = 0; q < NQ; q++) pop_check("R10");
        check(evq_count == 0, "R10", int'(evq_count), 0);

        finish_up();
    end
endmodule